// File: doc/BRIEF.md
# Tamper Event Latch with Timestamp

This block collects tamper indications from nine sources: two asynchronous digital tamper pins, four comparator result bits, an over-temperature flag, a temperature-slew flag and a flag that reports the crystal oscillator running outside its allowed frequency window. A per-source enable bit qualifies each indication. A qualified event sets a sticky status bit, which stays set until the host clears it with a write-one-to-clear. The first event after an all-clear status records the value of an external 32-bit seconds counter. Each source owns an 8-bit memory-bank mask. On the cycle after one or more sources become newly latched, the block sends the OR of their masks to the secure memory as a one-cycle erase request.

The digital pins are resynchronised by two flops. A pin then counts as asserted only after it has stayed high for longer than a programmable number of clock cycles, so short glitches are filtered out. The other sources are taken to be synchronous level flags. A simple register port lets the host set up enables, the filter length and the masks, and read back status and the timestamp. Reads are combinational.

Top module: `tamper_latch_ts`

## Requirements
- R1: After reset, the enable, status, timestamp, filter length and all bank masks read 0, `erase_vld_o` is 0, `erase_mask_o` is 0 and `tamper_o` is 0.
- R2: A source whose enable bit is 0 never sets its status bit, and it causes no erase request.
- R3: A status bit stays set until a write to the status address with a 1 in that bit position. Bits written with 0 are left unchanged.
- R4: If a source is active and enabled in the same cycle that its status bit is written with 1, the bit stays set.
- R5: The timestamp loads `sec_cnt_i` at the clock edge where a status bit sets while every status bit is clear (after that cycle's clear is applied). While any status bit remains set, the timestamp holds its value, and a full clear alone does not change it.
- R6: One cycle after a clock edge at which sources become newly latched, `erase_vld_o` is 1 for one cycle and `erase_mask_o` equals the OR of those sources' masks. A source that is already latched and stays active raises no further request.
- R7: A digital pin that is high for N consecutive cycles, with filter length F, latches only if N > F. When it does latch, its status bit is visible F+3 clock edges after the pin first goes high.
- R8: The register map is as follows. Address 0 holds the enable bits and address 1 the status bits. Both use bit 0 for pin 0, bit 1 for pin 1, bits 2 to 5 for comparators 0 to 3, bit 6 for over-temperature, bit 7 for temperature slew and bit 8 for oscillator out of window. Address 2 holds the timestamp, address 3 the filter length in bits 7:0, and addresses 4 to 12 the 8-bit mask of source 0 to 8.
- R9: `tamper_o` is 1 exactly when any status bit is set.
- R10: Reads of addresses 13 to 15 return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sec_cnt_i | input | 32 | Running seconds count used as timestamp |
| pin_i | input | 2 | Asynchronous digital tamper pins |
| cmp_i | input | 4 | Comparator tamper results |
| over_temp_i | input | 1 | Absolute temperature out of range |
| temp_slew_i | input | 1 | Temperature rate of change beyond limit |
| osc_bad_i | input | 1 | Oscillator frequency outside window |
| reg_addr_i | input | 4 | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data |
| erase_vld_o | output | 1 | One-cycle bank-erase request |
| erase_mask_o | output | 8 | Banks to erase |
| tamper_o | output | 1 | Any tamper latched |

## Verification
Level sources and status writes take effect at the next clock edge, so status, timestamp and erase outputs are sampled one time unit after the edge that follows the stimulus. Erase outputs are also checked again one edge later to confirm they have returned to 0. Pin events reach status at edge F+3, so the bench checks the exact edge: still clear after edge F+2 and set after edge F+3. Glitches of F cycles are checked against status after the pipeline has drained. The random phase steps a bench model once per edge and compares status, timestamp, erase outputs and `tamper_o` after every edge.

// File: rtl/tamper_latch_ts.sv
module tamper_latch_ts #(
  parameter int TS_W   = 32,
  parameter int MASK_W = 8,
  parameter int FILT_W = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int NPIN   = 2,
  parameter int NCMP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TS_W-1:0]   sec_cnt_i,
  input  logic [NPIN-1:0]   pin_i,
  input  logic [NCMP-1:0]   cmp_i,
  input  logic              over_temp_i,
  input  logic              temp_slew_i,
  input  logic              osc_bad_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              erase_vld_o,
  output logic [MASK_W-1:0] erase_mask_o,
  output logic              tamper_o
);
  localparam int NSRC   = NPIN + NCMP + 3;
  localparam int A_EN   = 0;
  localparam int A_STAT = 1;
  localparam int A_TS   = 2;
  localparam int A_FILT = 3;
  localparam int A_MASK = 4;

  logic [NSRC-1:0]   en_q, st_q, clr_v, evt, new_v, st_after_clr;
  logic [TS_W-1:0]   ts_q;
  logic [FILT_W-1:0] filt_q;
  logic [MASK_W-1:0] mask_q [NSRC];
  logic [NPIN-1:0]   pin_qual;
  logic [MASK_W-1:0] erase_v;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic s1, s2;
    logic [FILT_W-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1  <= 1'b0;
        s2  <= 1'b0;
        cnt <= '0;
      end else begin
        s1 <= pin_i[p];
        s2 <= s1;
        if (!s2) cnt <= '0;
        else if (cnt != '1) cnt <= cnt + 1'b1;
      end
    end
    assign pin_qual[p] = s2 && (cnt >= filt_q);
  end

  wire wr_stat = reg_we_i && (reg_addr_i == ADDR_W'(A_STAT));
  assign clr_v        = wr_stat ? reg_wdata_i[NSRC-1:0] : '0;
  assign evt          = {osc_bad_i, temp_slew_i, over_temp_i, cmp_i, pin_qual} & en_q;
  assign st_after_clr = st_q & ~clr_v;
  assign new_v        = evt & ~st_after_clr;
  assign tamper_o     = |st_q;

  always_comb begin
    erase_v = '0;
    for (int i = 0; i < NSRC; i++)
      if (new_v[i]) erase_v = erase_v | mask_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q         <= '0;
      st_q         <= '0;
      ts_q         <= '0;
      filt_q       <= '0;
      erase_vld_o  <= 1'b0;
      erase_mask_o <= '0;
      for (int i = 0; i < NSRC; i++) mask_q[i] <= '0;
    end else begin
      st_q         <= st_after_clr | new_v;
      erase_vld_o  <= |new_v;
      erase_mask_o <= (|new_v) ? erase_v : '0;
      if ((st_after_clr == '0) && (|new_v)) ts_q <= sec_cnt_i;
      if (reg_we_i) begin
        if (reg_addr_i == ADDR_W'(A_EN))   en_q   <= reg_wdata_i[NSRC-1:0];
        if (reg_addr_i == ADDR_W'(A_FILT)) filt_q <= reg_wdata_i[FILT_W-1:0];
        for (int i = 0; i < NSRC; i++)
          if (reg_addr_i == ADDR_W'(A_MASK + i)) mask_q[i] <= reg_wdata_i[MASK_W-1:0];
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_W'(A_EN):   reg_rdata_o = DATA_W'(en_q);
      ADDR_W'(A_STAT): reg_rdata_o = DATA_W'(st_q);
      ADDR_W'(A_TS):   reg_rdata_o = DATA_W'(ts_q);
      ADDR_W'(A_FILT): reg_rdata_o = DATA_W'(filt_q);
      default: begin
        for (int i = 0; i < NSRC; i++)
          if (reg_addr_i == ADDR_W'(A_MASK + i)) reg_rdata_o = DATA_W'(mask_q[i]);
      end
    endcase
  end
endmodule

module tamper_latch_ts_chk #(
  parameter int NSRC = 9,
  parameter int TS_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] st,
  input logic [NSRC-1:0] en,
  input logic [NSRC-1:0] clr,
  input logic [TS_W-1:0] ts,
  input logic            erase_vld
);
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(st) & ~$past(clr) & ~st) == '0)); // R3
  AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((st & ~$past(st) & ~$past(en)) == '0)); // R2
  AST_TS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(st) & ~$past(clr)) != '0) |-> $stable(ts)); // R5
  AST_ERASE_HAS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    erase_vld |-> (st != '0)); // R6
endmodule

bind tamper_latch_ts tamper_latch_ts_chk #(.NSRC(NSRC), .TS_W(TS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .st(st_q), .en(en_q), .clr(clr_v),
  .ts(ts_q), .erase_vld(erase_vld_o));

// File: tb/tamper_latch_ts_tb.sv
module tamper_latch_ts_tb_top;
  localparam int CLK_P = 10;
  localparam int NSRC  = 9;

  logic clk = 0, rst_n = 0;
  logic [31:0] sec_cnt = 0;
  logic [1:0]  pin = 0;
  logic [3:0]  cmp = 0;
  logic over_temp = 0, temp_slew = 0, osc_bad = 0;
  logic [3:0]  addr = 0;
  logic        we = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        erase_vld;
  logic [7:0]  erase_mask;
  logic        tamper;

  int total = 0, bad = 0;
  logic [7:0] m [NSRC];
  logic [NSRC-1:0] st_m, en_m;
  logic [31:0] ts_m;

  always #(CLK_P/2) clk = ~clk;

  tamper_latch_ts dut_i (
    .clk(clk), .rst_n(rst_n), .sec_cnt_i(sec_cnt), .pin_i(pin), .cmp_i(cmp),
    .over_temp_i(over_temp), .temp_slew_i(temp_slew), .osc_bad_i(osc_bad),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .erase_vld_o(erase_vld), .erase_mask_o(erase_mask), .tamper_o(tamper));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [31:0] rd(logic [3:0] a);
    return 32'(a);
  endfunction

  task automatic rdchk(string req, logic [3:0] a, logic [31:0] exp);
    addr = a; we = 0; #1;
    chk(req, rdata, exp);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1;
    tick();
    we = 0;
  endtask

  function automatic logic [7:0] or_masks(logic [NSRC-1:0] v);
    logic [7:0] r = 0;
    for (int i = 0; i < NSRC; i++) if (v[i]) r |= m[i];
    return r;
  endfunction

  initial begin
    #(CLK_P * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [NSRC-1:0] clr, evt, nw, ca;
    logic [7:0] exp_mask;
    logic       exp_vld;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // R1 reset state
    rdchk("R1 enable", 4'd0, 0);
    rdchk("R1 status", 4'd1, 0);
    rdchk("R1 timestamp", 4'd2, 0);
    rdchk("R1 filter", 4'd3, 0);
    for (int i = 0; i < NSRC; i++) rdchk("R1 mask", 4'(4 + i), 0);
    chk("R1 erase_vld", 32'(erase_vld), 0);
    chk("R1 erase_mask", 32'(erase_mask), 0);
    chk("R1 tamper_o", 32'(tamper), 0);

    // R8 masks
    for (int i = 0; i < NSRC; i++) begin
      m[i] = (i == 8) ? 8'h81 : (8'h01 << i);
      wr(4'(4 + i), 32'(m[i]));
    end
    for (int i = 0; i < NSRC; i++) rdchk("R8 mask readback", 4'(4 + i), 32'(m[i]));

    // R10 unmapped
    wr(4'd14, 32'hFFFF_FFFF);
    rdchk("R10 unmapped read", 4'd14, 0);
    rdchk("R10 enable untouched", 4'd0, 0);

    // R2 disabled source
    over_temp = 1; tick(); over_temp = 0;
    chk("R2 no erase", 32'(erase_vld), 0);
    rdchk("R2 status", 4'd1, 0);

    wr(4'd0, 32'h1FF);
    rdchk("R8 enable readback", 4'd0, 32'h1FF);

    // R5/R6 first event, comparator 1 -> bit 3
    sec_cnt = 100; cmp = 4'b0010; tick(); cmp = 0;
    chk("R6 erase_vld", 32'(erase_vld), 1);
    chk("R6 erase_mask", 32'(erase_mask), 32'(m[3]));
    chk("R9 tamper_o", 32'(tamper), 1);
    rdchk("R8 status bit3", 4'd1, 32'h008);
    rdchk("R5 first timestamp", 4'd2, 100);
    tick();
    chk("R6 pulse one cycle", 32'(erase_vld), 0);

    sec_cnt = 200; over_temp = 1; tick(); over_temp = 0;
    chk("R6 second erase mask", 32'(erase_mask), 32'(m[6]));
    rdchk("R3 status accumulates", 4'd1, 32'h048);
    rdchk("R5 timestamp held", 4'd2, 100);

    osc_bad = 1; tick();
    chk("R6 osc erase", 32'(erase_mask), 32'h81);
    tick(); osc_bad = 0;
    chk("R6 no repeat when latched", 32'(erase_vld), 0);

    wr(4'd1, 32'h008);
    rdchk("R3 partial clear", 4'd1, 32'h140);
    rdchk("R5 timestamp after partial clear", 4'd2, 100);

    over_temp = 1; wr(4'd1, 32'h040); over_temp = 0;
    rdchk("R4 set wins", 4'd1, 32'h140);

    sec_cnt = 300; wr(4'd1, 32'h1FF);
    rdchk("R3 full clear", 4'd1, 0);
    chk("R9 tamper_o clear", 32'(tamper), 0);
    rdchk("R5 timestamp after clear only", 4'd2, 100);
    temp_slew = 1; tick(); temp_slew = 0;
    rdchk("R5 recapture", 4'd2, 300);
    rdchk("R8 slew bit7", 4'd1, 32'h080);
    wr(4'd1, 32'h1FF);

    // R7 pin filter F=4
    wr(4'd3, 32'd4);
    rdchk("R8 filter readback", 4'd3, 4);
    pin = 2'b01; repeat (4) tick(); pin = 0;
    repeat (8) tick();
    rdchk("R7 glitch of F ignored", 4'd1, 0);
    pin = 2'b10;
    repeat (6) tick();
    rdchk("R7 not yet at edge F+2", 4'd1, 0);
    tick();
    rdchk("R7 latched at edge F+3", 4'd1, 32'h002);
    pin = 0;
    chk("R6 pin1 erase", 32'(erase_mask), 32'(m[1]));
    repeat (4) tick();
    wr(4'd1, 32'h1FF);

    // random phase on synchronous sources
    void'($urandom(1234));
    st_m = 0; ts_m = 300; en_m = 9'h1FF;
    for (int it = 0; it < 400; it++) begin
      if ((it % 50) == 0) begin
        en_m = 9'($urandom) & 9'h1FC;
        wr(4'd0, 32'(en_m));
        chk("R2 random enable", 32'(erase_vld), 0);
      end
      cmp = 4'($urandom); over_temp = 1'($urandom); temp_slew = 1'($urandom);
      osc_bad = 1'($urandom);
      if (($urandom % 4) != 0) begin cmp = 0; over_temp = 0; temp_slew = 0; osc_bad = 0; end
      sec_cnt = sec_cnt + ($urandom % 3);
      clr = 0;
      if (($urandom % 3) == 0) begin
        clr = 9'($urandom);
        addr = 4'd1; wdata = 32'(clr); we = 1;
      end
      evt = {osc_bad, temp_slew, over_temp, cmp, 2'b00} & en_m;
      ca = st_m & ~clr;
      nw = evt & ~ca;
      if (ca == 0 && nw != 0) ts_m = sec_cnt;
      st_m = ca | nw;
      exp_vld = (nw != 0);
      exp_mask = exp_vld ? or_masks(nw) : 8'h00;
      tick();
      we = 0;
      chk("R6 random erase_vld", 32'(erase_vld), 32'(exp_vld));
      chk("R6 random erase_mask", 32'(erase_mask), 32'(exp_mask));
      chk("R9 random tamper_o", 32'(tamper), 32'(st_m != 0));
      rdchk("R3 random status", 4'd1, 32'(st_m));
      rdchk("R5 random timestamp", 4'd2, ts_m);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule